// File: doc/BRIEF.md
# Segmented Aligned Memory Read Unit

This unit sits between a requester and a 16-bit memory bus that can only fetch from even byte addresses. The requester gives a 16-bit segment, a 16-bit offset and a size (byte or word). The unit shifts the segment left by four bits and adds the offset, which gives a 20-bit physical byte address. It then runs one or two bus reads and assembles the result with the correct byte lanes.

A word at an even address takes one bus read. A word at an odd address is split into two even-aligned reads. The upper lane of the first read becomes the low byte of the result, and the lower lane of the second read becomes the high byte. A byte read keeps one lane, chosen by address bit 0, and returns it zero-extended. A new request is taken only while the unit is idle. A one-cycle done pulse marks the point where the result is valid.

Top module: `segAlignReader`

## Requirements
- R1: The physical address is (segment × 16 + offset) modulo 2^20. The first bus read goes to that address with bit 0 cleared.
- R2: Whenever `busRead` is high, `busAddr[0]` is 0.
- R3: A word request at an even address makes exactly one bus read. The result is `busData` as returned: the lower lane (bits 7:0) holds the byte at the address and the upper lane holds the byte at the address + 1.
- R4: A word request at an odd address P makes two bus reads, first at P−1 and then at P+1, with two clock cycles between the strobes. The result is {lower lane of the second read, upper lane of the first read}.
- R5: A byte request at an even address returns the lower lane of its single read in `rdData[7:0]`, with `rdData[15:8]` = 0.
- R6: A byte request at an odd address returns the upper lane of its single read in `rdData[7:0]`, with `rdData[15:8]` = 0.
- R7: Address arithmetic wraps modulo 2^20. This applies both to the segment-plus-offset sum and to the second read of a split word (an odd word at FFFFFh reads FFFFEh, then 00000h).
- R8: Read data is sampled in the cycle after the `busRead` strobe. For a request sampled at clock edge n, the first read strobe is high in the cycle after edge n. `rdDone` is high for exactly one cycle, following edge n+2 for a single-read request or edge n+4 for a split request, and `rdData` is valid in that cycle.
- R9: `reqValid` is ignored while a request is in progress. It causes no extra bus reads and no extra done pulses. A request offered during the done cycle is accepted.
- R10: After reset, `busRead` and `rdDone` are 0 and `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqSeg | input | 16 | Segment value |
| reqOff | input | 16 | Offset within the segment |
| reqWord | input | 1 | 1 = word read, 0 = byte read |
| busAddr | output | 20 | Even byte address for the memory read |
| busRead | output | 1 | Memory read strobe |
| busData | input | 16 | Read data, valid the cycle after the strobe |
| rdData | output | 16 | Assembled result, zero-extended for bytes |
| rdDone | output | 1 | One-cycle pulse, result valid |

## Verification
The bench targets the following corner cases:

- **Odd word split.** A design that swapped lanes or kept the wrong byte of either read would return a byte-swapped or shifted word.
- **Wrap at the top of the address space.** This covers both the sum overflow and the second read of a split word at FFFFFh. An unmasked adder would present a 21-bit carry or read 100000h instead of 00000h.
- **Byte lane choice by address parity.** A wrong choice returns the neighbouring byte, or leaves garbage in the upper half of the result.
- **Busy and done-cycle timing.** Requests are held high while the unit is busy and issued back to back in the done cycle. A unit that accepted while busy would emit stray reads. One that refused during the done cycle would lag the model by a cycle.

// File: rtl/memAlignPkg.sv
package memAlignPkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadReq;    // capture segment, offset, size
    logic useNext;    // drive the second (next even) address
    logic capFirst;   // capture data of the first read
    logic capSecond;  // capture data of the second read
  } alignStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ISSUE1 = 3'd1,
    ST_CAP1   = 3'd2,
    ST_ISSUE2 = 3'd3,
    ST_CAP2   = 3'd4
  } alignState_t;
endpackage

// File: rtl/alignDatapath.sv
module alignDatapath
  import memAlignPkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PHYS_W    = 20,
  parameter int DATA_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  alignStrobes_t       strobes,
  input  logic [SEG_W-1:0]    reqSeg,
  input  logic [OFF_W-1:0]    reqOff,
  input  logic                reqWord,
  input  logic [DATA_W-1:0]   busData,
  output logic [PHYS_W-1:0]   busAddr,
  output logic                needSecond,
  output logic [DATA_W-1:0]   rdData
);
  localparam int LANE_W = DATA_W / 2;
  localparam int STEP   = DATA_W / 8;

  logic [PHYS_W-1:0] physAddr;
  logic              wordReg;
  logic [LANE_W-1:0] keptLow;
  logic [DATA_W-1:0] resultReg;
  logic [PHYS_W-1:0] segShifted;
  logic [PHYS_W-1:0] physSum;
  logic [PHYS_W-1:0] baseEven;
  logic [PHYS_W-1:0] nextEven;
  logic [LANE_W-1:0] lowLane;
  logic [LANE_W-1:0] highLane;

  // Segment shifted and offset added, kept to PHYS_W bits (wraps)
  always_comb begin
    segShifted = PHYS_W'(reqSeg) << SEG_SHIFT;
    physSum    = segShifted + PHYS_W'(reqOff);
  end

  assign baseEven   = {physAddr[PHYS_W-1:1], 1'b0};
  assign nextEven   = baseEven + PHYS_W'(STEP);
  assign busAddr    = strobes.useNext ? nextEven : baseEven;
  assign needSecond = wordReg & physAddr[0];
  assign lowLane    = busData[LANE_W-1:0];
  assign highLane   = busData[DATA_W-1:LANE_W];
  assign rdData     = resultReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physAddr  <= '0;
      wordReg   <= 1'b0;
      keptLow   <= '0;
      resultReg <= '0;
    end else begin
      if (strobes.loadReq) begin
        physAddr <= physSum;
        wordReg  <= reqWord;
      end
      if (strobes.capFirst) begin
        if (wordReg && physAddr[0]) begin
          keptLow <= highLane;
        end else if (wordReg) begin
          resultReg <= busData;
        end else begin
          resultReg <= {LANE_W'(0), physAddr[0] ? highLane : lowLane};
        end
      end
      if (strobes.capSecond) begin
        resultReg <= {lowLane, keptLow};
      end
    end
  end

  // R4: the second read address sits one bus word above the first
  second_addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.useNext |-> (busAddr == PHYS_W'(baseEven + PHYS_W'(STEP))));
endmodule

// File: rtl/alignControl.sv
module alignControl
  import memAlignPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          needSecond,
  output alignStrobes_t strobes,
  output logic          busRead,
  output logic          rdDone
);
  alignState_t state, nextState;

  always_comb begin
    strobes   = '0;
    busRead   = 1'b0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        strobes.loadReq = reqValid;
        if (reqValid) nextState = ST_ISSUE1;
      end
      ST_ISSUE1: begin
        busRead   = 1'b1;
        nextState = ST_CAP1;
      end
      ST_CAP1: begin
        strobes.capFirst = 1'b1;
        nextState = needSecond ? ST_ISSUE2 : ST_IDLE;
      end
      ST_ISSUE2: begin
        busRead         = 1'b1;
        strobes.useNext = 1'b1;
        nextState       = ST_CAP2;
      end
      ST_CAP2: begin
        strobes.capSecond = 1'b1;
        strobes.useNext   = 1'b1;
        nextState         = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rdDone <= 1'b0;
    end else begin
      state  <= nextState;
      rdDone <= (state == ST_CAP1 && !needSecond) || (state == ST_CAP2);
    end
  end

  // R8
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |=> !rdDone);

  // R8
  done_after_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdDone) |-> ($past(state) == ST_CAP1 || $past(state) == ST_CAP2));

  // R3
  read_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRead |=> !busRead);

  // R4
  second_read_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ISSUE2) |-> ($past(state) == ST_CAP1));
endmodule

// File: rtl/segAlignReader.sv
module segAlignReader
  import memAlignPkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PHYS_W    = 20,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic              reqWord,
  output logic [PHYS_W-1:0] busAddr,
  output logic              busRead,
  input  logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDone
);
  alignStrobes_t strobes;
  logic          needSecond;

  alignControl ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .needSecond(needSecond),
    .strobes(strobes), .busRead(busRead), .rdDone(rdDone)
  );

  alignDatapath #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT),
    .PHYS_W(PHYS_W), .DATA_W(DATA_W)
  ) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqSeg(reqSeg),
    .reqOff(reqOff), .reqWord(reqWord), .busData(busData),
    .busAddr(busAddr), .needSecond(needSecond), .rdData(rdData)
  );

  // R2
  even_bus_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRead |-> !busAddr[0]);

  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!busRead && !rdDone));
endmodule

// File: tb/segAlignReader_test.sv
module segAlignReader_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqSeg = '0;
  logic [15:0] reqOff = '0;
  logic        reqWord = 1'b0;
  logic [19:0] busAddr;
  logic        busRead;
  logic [15:0] busData = 16'hC3C3;
  logic [15:0] rdData;
  logic        rdDone;

  int checks = 0;
  int fails = 0;
  bit running = 1'b0;

  // Expected per-cycle behaviour, one entry per clock cycle
  bit          qRd[$];
  logic [19:0] qAddr[$];
  bit          qDone[$];
  logic [15:0] qData[$];
  string       qTag[$];

  always #10 clk = ~clk;

  segAlignReader uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSeg(reqSeg),
    .reqOff(reqOff), .reqWord(reqWord), .busAddr(busAddr),
    .busRead(busRead), .busData(busData), .rdData(rdData), .rdDone(rdDone)
  );

  function automatic logic [7:0] memByte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[3:0]} ^ 8'h3C;
  endfunction

  // Memory: data for the strobed address appears the next cycle
  always @(posedge clk) begin
    if (busRead) busData <= {memByte(20'(busAddr + 20'd1)), memByte(busAddr)};
    else         busData <= 16'hC3C3;
  end

  task automatic pushCycle(bit rd, logic [19:0] a, bit dn, logic [15:0] d, string t);
    qRd.push_back(rd); qAddr.push_back(a); qDone.push_back(dn);
    qData.push_back(d); qTag.push_back(t);
  endtask

  // Reference model: accept only when no transaction is outstanding
  always @(posedge clk) begin
    if (rstN && reqValid && qRd.size() == 0) begin
      logic [20:0] full;
      logic [19:0] p, e, e2;
      logic [15:0] res;
      string t;
      full = {1'b0, reqSeg, 4'h0} + 21'(reqOff);
      p  = full[19:0];
      e  = {p[19:1], 1'b0};
      e2 = 20'(e + 20'd2);
      res = reqWord ? {memByte(20'(p + 20'd1)), memByte(p)} : {8'h00, memByte(p)};
      t = reqWord ? (p[0] ? "R4" : "R3") : (p[0] ? "R6" : "R5");
      t = {t, " R1 R2 R8"};
      if (full[20] || (reqWord && p == 20'hFFFFF)) t = {t, " R7"};
      pushCycle(1, e, 0, 16'h0, t);
      pushCycle(0, e, 0, 16'h0, t);
      if (reqWord && p[0]) begin
        pushCycle(1, e2, 0, 16'h0, t);
        pushCycle(0, e2, 0, 16'h0, t);
      end
      pushCycle(0, e, 1, res, t);
    end
  end

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      bit rd, dn; logic [19:0] a; logic [15:0] d; string t;
      if (qRd.size() != 0) begin
        rd = qRd.pop_front(); a = qAddr.pop_front(); dn = qDone.pop_front();
        d = qData.pop_front(); t = qTag.pop_front();
      end else begin
        rd = 0; a = '0; dn = 0; d = '0; t = "R9 idle";
      end
      check(busRead == rd, t, "busRead", 32'(busRead), 32'(rd));
      if (rd) check(busAddr == a, t, "busAddr", 32'(busAddr), 32'(a));
      check(rdDone == dn, t, "rdDone", 32'(rdDone), 32'(dn));
      if (dn) check(rdData == d, t, "rdData", 32'(rdData), 32'(d));
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic waitIdle();
    do begin
      @(negedge clk); #1;
    end while (qRd.size() != 0);
  endtask

  // Offer a request once the model is idle; holdBusy keeps reqValid high longer (R9)
  task automatic sendReq(logic [15:0] s, logic [15:0] o, bit w, int holdBusy);
    waitIdle();
    reqSeg = s; reqOff = o; reqWord = w; reqValid = 1'b1;
    @(negedge clk); #1;
    for (int k = 0; k < holdBusy; k++) begin
      reqSeg = reqSeg ^ 16'h0101; reqOff = reqOff + 16'd3;
      @(negedge clk); #1;
    end
    reqValid = 1'b0;
  endtask

  // Back-to-back: the next request is offered in the done cycle (R9)
  task automatic sendPair(logic [15:0] s, logic [15:0] o);
    waitIdle();
    reqSeg = s; reqOff = o; reqWord = 1'b1; reqValid = 1'b1;
    @(negedge clk); #1;
    reqValid = 1'b0;
    waitIdle();
    check(rdDone == 1'b1, "R9", "done cycle before back-to-back", 32'(rdDone), 32'd1);
    reqSeg = s; reqOff = o + 16'd1; reqWord = 1'b1; reqValid = 1'b1;
    @(negedge clk); #1;
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", "timeout", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busRead == 1'b0, "R10", "busRead in reset", 32'(busRead), 32'd0);
    check(rdDone == 1'b0, "R10", "rdDone in reset", 32'(rdDone), 32'd0);
    check(rdData == 16'h0, "R10", "rdData in reset", 32'(rdData), 32'd0);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk); #1;
    check(rdData == 16'h0, "R10", "rdData after reset", 32'(rdData), 32'd0);
    sendReq(16'h1230, 16'h0045, 1'b0, 0);   // R1 R6: 12345h odd byte
    sendReq(16'h1230, 16'h0044, 1'b1, 0);   // R3 even word
    sendReq(16'h1230, 16'h0045, 1'b1, 0);   // R4 odd word
    sendReq(16'h0000, 16'h0520, 1'b0, 0);   // R5 even byte
    sendReq(16'hF000, 16'hFFFF, 1'b1, 0);   // R7 odd word at FFFFFh
    sendReq(16'hFFFF, 16'h0011, 1'b0, 0);   // R7 sum overflow, odd byte
    sendReq(16'hFFFF, 16'h0010, 1'b1, 0);   // R7 even word after wrap
    sendReq(16'h0100, 16'h0033, 1'b1, 2);   // R9 held while busy
    sendReq(16'h0200, 16'h0040, 1'b0, 1);   // R9 held on short request
    sendPair(16'h4000, 16'h1234);           // R8 R9 back to back
    for (int i = 0; i < 40; i++) begin
      sendReq(16'($urandom), 16'($urandom), 1'($urandom), int'($urandom % 3));
    end
    waitIdle();
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule